// File: doc/BRIEF.md
# Differential Command Uplink Receiver with Boot Loader

This block takes the sliced one-bit command uplink and turns it into 32-bit command words. A digital phase-locked loop runs at 16 ticks of an oversampling strobe per bit. It moves its phase toward each transition it observes and samples the line halfway through the bit. Each recovered symbol is then differentially decoded, so the sense of the line carries no meaning. A lock detector follows how close transitions fall to the expected bit boundary. While the receiver is locked, a framer looks for a fixed 32-bit sync pattern and then packs every later bit into 32-bit words, most significant bit first.

The words go to one of two places. After reset, or after a reload command, the block is in load mode. It writes each word directly into program memory through a one-cycle write strobe, and holds the processor off until the last of a configured number of words has been written. After that the block is in run mode: each word is held on an output and announced by a one-cycle interrupt pulse.

Top module: `cmd_uplink_rx`

## Requirements
- R1: The loop counts OSR (16) ticks per bit and moves its phase by one tick toward each input transition. It recovers the data correctly for any starting phase offset between the line and the loop.
- R2: A decoded bit is 1 when the sampled symbol differs from the one before it, and 0 when it does not. Inverting the line therefore leaves the decoded data unchanged.
- R3: lock_o is 0 after reset. It goes to 1 only after 32 consecutive transitions that each fall within 2 ticks of the expected boundary.
- R4: Once lock_o is 1, it stays 1 through six consecutive transitions outside the window. It goes to 0 after the eighth consecutive such transition.
- R5: Word packing starts with the first decoded bit after the 32-bit sync pattern, which is SYNC_WORD and is matched only while locked. The first decoded bit becomes bit 31 of the word. Loss of lock sends the framer back to searching.
- R6: After reset, the first BOOT_WORDS words are written in order to addresses BASE_ADDR+0, +1, and so on, each with a single-cycle mem_we_o. hold_cpu_o is 1 during every one of these writes.
- R7: hold_cpu_o falls exactly one cycle after the write strobe of the final load word. No interrupt is raised while hold_cpu_o is 1.
- R8: In run mode, each word gives a single-cycle irq_o, with word_o carrying that word, and causes no memory write.
- R9: A reload_i pulse sets hold_cpu_o on the next cycle. The next BOOT_WORDS words are then written again starting at BASE_ADDR.
- R10: During reset hold_cpu_o is 1, and lock_o, mem_we_o and irq_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Oversampling strobe, OSR per bit |
| rx_i | input | 1 | Sliced line input, asynchronous |
| reload_i | input | 1 | Pulse that re-enters load mode |
| lock_o | output | 1 | Bit-clock lock indicator |
| hold_cpu_o | output | 1 | Holds the processor off during load |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | ADDR_W | Memory write address |
| mem_data_o | output | 32 | Memory write data |
| irq_o | output | 1 | Word-ready interrupt pulse |
| word_o | output | 32 | Last word delivered in run mode |

## Verification
The assertions assume that assembled words arrive at least two clock cycles apart, so write strobes can never be back to back. They also assume that hold_cpu_o is raised only by reset or by reload_i. Both hold for any line that runs at 16 ticks per bit. The stimulus keeps every symbol exactly 16 ticks long, with edges on tick boundaries. It adds single-tick glitches only inside a symbol and away from mid-bit, so phase errors stay bounded and sampling stays clean. Each run sweeps the initial phase offset and the line polarity.

// File: rtl/cmd_uplink_pkg.sv
package cmd_uplink_pkg;
  typedef enum logic {FRM_HUNT, FRM_DATA} frm_state_e;
endpackage

// File: rtl/uplink_dpll.sv
module uplink_dpll #(
  parameter int OSR         = 16,
  parameter int TOL         = 2,
  parameter int LOCK_IN     = 32,
  parameter int LOCK_MISS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic rx_i,
  output logic bit_vld_o,
  output logic bit_o,
  output logic lock_o
);
  localparam int PH_W = $clog2(OSR);
  localparam int HALF = OSR / 2;
  localparam int GC_W = $clog2(LOCK_IN + 1);
  localparam int MC_W = $clog2(LOCK_MISS + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic rx_s, rx_q, edge_w, good_w;
  logic [PH_W-1:0] ph_q, dist_w;
  logic [GC_W-1:0] good_q;
  logic [MC_W-1:0] miss_q;

  // input synchronizer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], rx_i};
  end
  assign rx_s = sync_q[SYNC_STAGES-1];

  assign edge_w = tick_i && (rx_s != rx_q);
  assign dist_w = (ph_q < PH_W'(HALF)) ? ph_q : (PH_W'(0) - ph_q);
  assign good_w = dist_w <= PH_W'(TOL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q      <= 1'b0;
      ph_q      <= '0;
      bit_vld_o <= 1'b0;
      bit_o     <= 1'b0;
    end else begin
      bit_vld_o <= 1'b0;
      if (tick_i) begin
        rx_q <= rx_s;
        if (ph_q == PH_W'(HALF)) begin
          bit_vld_o <= 1'b1;
          bit_o     <= rx_s;
        end
        // late edge: hold one tick; early edge: skip one tick
        if (edge_w && ph_q != '0 && ph_q < PH_W'(HALF)) ph_q <= ph_q;
        else if (edge_w && ph_q >= PH_W'(HALF))         ph_q <= ph_q + PH_W'(2);
        else                                             ph_q <= ph_q + PH_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_o <= 1'b0;
      good_q <= '0;
      miss_q <= '0;
    end else if (edge_w) begin
      if (!lock_o) begin
        if (!good_w) good_q <= '0;
        else if (good_q == GC_W'(LOCK_IN - 1)) begin
          lock_o <= 1'b1;
          good_q <= '0;
          miss_q <= '0;
        end else good_q <= good_q + GC_W'(1);
      end else begin
        if (good_w) miss_q <= '0;
        else if (miss_q == MC_W'(LOCK_MISS - 1)) begin
          lock_o <= 1'b0;
          miss_q <= '0;
          good_q <= '0;
        end else miss_q <= miss_q + MC_W'(1);
      end
    end
  end
endmodule

// File: rtl/uplink_framer.sv
module uplink_framer
  import cmd_uplink_pkg::*;
#(
  parameter int          WORD_W    = 32,
  parameter int          SYNC_W    = 32,
  parameter logic [SYNC_W-1:0] SYNC_WORD = 32'h0F5AC3E1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_vld_i,
  input  logic              bit_i,
  input  logic              lock_i,
  output logic              word_vld_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int CNT_W = $clog2(WORD_W);

  frm_state_e        st_q;
  logic              prev_q, dbit_w;
  logic [SYNC_W-1:0] sr_q, sr_nxt;
  logic [WORD_W-1:0] acc_q, acc_nxt;
  logic [CNT_W-1:0]  cnt_q;

  assign dbit_w  = bit_i ^ prev_q;
  assign sr_nxt  = {sr_q[SYNC_W-2:0], dbit_w};
  assign acc_nxt = {acc_q[WORD_W-2:0], dbit_w};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= FRM_HUNT;
      prev_q     <= 1'b0;
      sr_q       <= '0;
      acc_q      <= '0;
      cnt_q      <= '0;
      word_vld_o <= 1'b0;
      word_o     <= '0;
    end else begin
      word_vld_o <= 1'b0;
      if (!lock_i) st_q <= FRM_HUNT;
      if (bit_vld_i) begin
        prev_q <= bit_i;
        sr_q   <= sr_nxt;
        if (st_q == FRM_HUNT) begin
          if (lock_i && sr_nxt == SYNC_WORD) begin
            st_q  <= FRM_DATA;
            cnt_q <= '0;
          end
        end else if (lock_i) begin
          acc_q <= acc_nxt;
          if (cnt_q == CNT_W'(WORD_W - 1)) begin
            cnt_q      <= '0;
            word_vld_o <= 1'b1;
            word_o     <= acc_nxt;
          end else cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/uplink_loader.sv
module uplink_loader #(
  parameter int              WORD_W     = 32,
  parameter int              ADDR_W     = 16,
  parameter int              BOOT_WORDS = 4,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reload_i,
  input  logic              word_vld_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              hold_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_data_o,
  output logic              irq_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int IDX_W = $clog2(BOOT_WORDS + 1);

  logic [IDX_W-1:0] idx_q;
  logic             last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_o     <= 1'b1;
      idx_q      <= '0;
      last_q     <= 1'b0;
      mem_we_o   <= 1'b0;
      mem_addr_o <= '0;
      mem_data_o <= '0;
      irq_o      <= 1'b0;
      word_o     <= '0;
    end else begin
      mem_we_o <= 1'b0;
      irq_o    <= 1'b0;
      if (mem_we_o && last_q) begin
        hold_o <= 1'b0;
        last_q <= 1'b0;
      end
      if (reload_i) begin
        hold_o <= 1'b1;
        idx_q  <= '0;
        last_q <= 1'b0;
      end else if (word_vld_i) begin
        if (hold_o && !last_q) begin
          mem_we_o   <= 1'b1;
          mem_addr_o <= BASE_ADDR + ADDR_W'(idx_q);
          mem_data_o <= word_i;
          if (idx_q == IDX_W'(BOOT_WORDS - 1)) last_q <= 1'b1;
          else idx_q <= idx_q + IDX_W'(1);
        end else if (!hold_o) begin
          irq_o  <= 1'b1;
          word_o <= word_i;
        end
      end
    end
  end
endmodule

// File: rtl/cmd_uplink_rx.sv
module cmd_uplink_rx #(
  parameter int              OSR        = 16,
  parameter int              TOL        = 2,
  parameter int              LOCK_IN    = 32,
  parameter int              LOCK_MISS  = 8,
  parameter int              WORD_W     = 32,
  parameter logic [31:0]     SYNC_WORD  = 32'h0F5AC3E1,
  parameter int              ADDR_W     = 16,
  parameter int              BOOT_WORDS = 4,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rx_i,
  input  logic              reload_i,
  output logic              lock_o,
  output logic              hold_cpu_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_data_o,
  output logic              irq_o,
  output logic [WORD_W-1:0] word_o
);
  logic              bit_vld, bit_val, word_vld;
  logic [WORD_W-1:0] word;

  uplink_dpll #(
    .OSR(OSR), .TOL(TOL), .LOCK_IN(LOCK_IN), .LOCK_MISS(LOCK_MISS), .SYNC_STAGES(2)
  ) u_dpll (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .rx_i(rx_i),
    .bit_vld_o(bit_vld), .bit_o(bit_val), .lock_o(lock_o)
  );

  uplink_framer #(
    .WORD_W(WORD_W), .SYNC_W(32), .SYNC_WORD(SYNC_WORD)
  ) u_frm (
    .clk_i(clk_i), .rst_ni(rst_ni), .bit_vld_i(bit_vld), .bit_i(bit_val),
    .lock_i(lock_o), .word_vld_o(word_vld), .word_o(word)
  );

  uplink_loader #(
    .WORD_W(WORD_W), .ADDR_W(ADDR_W), .BOOT_WORDS(BOOT_WORDS), .BASE_ADDR(BASE_ADDR)
  ) u_ldr (
    .clk_i(clk_i), .rst_ni(rst_ni), .reload_i(reload_i), .word_vld_i(word_vld),
    .word_i(word), .hold_o(hold_cpu_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_data_o(mem_data_o), .irq_o(irq_o), .word_o(word_o)
  );
endmodule

// File: rtl/cmd_uplink_rx_chk.sv
module cmd_uplink_rx_chk #(
  parameter int              ADDR_W     = 16,
  parameter int              BOOT_WORDS = 4,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0100
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reload_i,
  input logic              hold_cpu_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              irq_o
);
  p_write_held_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> hold_cpu_o);
  p_write_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !mem_we_o);
  p_write_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (ADDR_W'(mem_addr_o - BASE_ADDR) < ADDR_W'(BOOT_WORDS)));
  p_release_after_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hold_cpu_o) |-> $past(mem_we_o));
  p_no_irq_held_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !hold_cpu_o);
  p_irq_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  p_hold_by_reload_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hold_cpu_o) |-> $past(reload_i));
endmodule

bind cmd_uplink_rx cmd_uplink_rx_chk #(
  .ADDR_W(ADDR_W), .BOOT_WORDS(BOOT_WORDS), .BASE_ADDR(BASE_ADDR)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reload_i(reload_i), .hold_cpu_o(hold_cpu_o),
  .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .irq_o(irq_o)
);

// File: tb/sim_cmd_uplink_rx.sv
`timescale 1ns/1ps
module sim_cmd_uplink_rx;
  localparam int          BOOT = 3;
  localparam logic [15:0] BASE = 16'h0040;
  localparam logic [31:0] SYNC = 32'h0F5AC3E1;
  localparam int          OSR  = 16;

  logic clk_i = 1'b0, rst_ni = 1'b0, tick_i = 1'b0, rx_i = 1'b0, reload_i = 1'b0;
  logic lock_o, hold_cpu_o, mem_we_o, irq_o;
  logic [15:0] mem_addr_o;
  logic [31:0] mem_data_o, word_o;

  always #4 clk_i = ~clk_i;

  cmd_uplink_rx #(.BOOT_WORDS(BOOT), .BASE_ADDR(BASE), .SYNC_WORD(SYNC)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .rx_i(rx_i), .reload_i(reload_i),
    .lock_o(lock_o), .hold_cpu_o(hold_cpu_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_data_o(mem_data_o), .irq_o(irq_o), .word_o(word_o)
  );

  int total = 0, bad = 0;
  logic sym = 1'b0;

  // monitor, sampled at the falling edge
  int cyc = 0, wr_cnt = 0, irq_cnt = 0, irq_bad = 0, we_bad = 0, last_wr = -1, fall_cyc = -2;
  logic [15:0] wr_addr [0:7];
  logic [31:0] wr_data [0:7];
  logic [31:0] irq_word [0:7];
  logic hold_prev = 1'b1;

  always @(negedge clk_i) begin
    cyc++;
    if (rst_ni) begin
      if (mem_we_o) begin
        if (!hold_cpu_o) we_bad++;
        if (wr_cnt < 8) begin wr_addr[wr_cnt] = mem_addr_o; wr_data[wr_cnt] = mem_data_o; end
        wr_cnt++;
        last_wr = cyc;
      end
      if (irq_o) begin
        if (hold_cpu_o) irq_bad++;
        if (irq_cnt < 8) irq_word[irq_cnt] = word_o;
        irq_cnt++;
      end
      if (hold_prev && !hold_cpu_o) fall_cyc = cyc;
    end
    hold_prev = hold_cpu_o;
  end

  task automatic clear_mon();
    wr_cnt = 0; irq_cnt = 0; irq_bad = 0; we_bad = 0; last_wr = -1; fall_cyc = -2;
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input int r, input int k);
    return (32'h9E3779B9 * (k + 1)) ^ (32'h01010101 * r);
  endfunction

  task automatic one_tick(input logic v);
    @(negedge clk_i); tick_i = 1'b1; rx_i = v;
    @(negedge clk_i); tick_i = 1'b0;
  endtask

  // one bit, differentially encoded; glitch at tick gpos (<0: none)
  task automatic send_bit(input logic b, input int gpos);
    sym = sym ^ b;
    for (int t = 0; t < OSR; t++) one_tick((t == gpos) ? ~sym : sym);
  endtask

  task automatic send_word(input logic [31:0] w);
    for (int i = 31; i >= 0; i--) send_bit(w[i], -1);
  endtask

  task automatic send_frame(input int r);
    send_word(SYNC);
    for (int k = 0; k < BOOT + 3; k++) send_word(exp_word(r, k));
    send_bit(1'b0, -1);
    send_bit(1'b0, -1);
  endtask

  task automatic check_load(input int r, input string req);
    chk(wr_cnt == BOOT, req, "write count", wr_cnt, BOOT);
    for (int k = 0; k < BOOT; k++) begin
      chk(wr_addr[k] == BASE + 16'(k), req, "write address", {16'h0, wr_addr[k]}, {16'h0, BASE + 16'(k)});
      chk(wr_data[k] == exp_word(r, k), {req, " R5 R2"}, "write data", wr_data[k], exp_word(r, k));
    end
    chk(fall_cyc == last_wr + 1, "R7", "hold release cycle", fall_cyc, last_wr + 1);
    chk(irq_bad == 0, "R7", "irq while held", irq_bad, 0);
  endtask

  task automatic do_run(input int r, input int offset, input logic pol);
    rst_ni = 1'b0; sym = pol; rx_i = pol; tick_i = 1'b0;
    repeat (4) @(negedge clk_i);
    chk(hold_cpu_o == 1'b1 && lock_o == 1'b0 && mem_we_o == 1'b0 && irq_o == 1'b0,
        "R10", "reset state", {hold_cpu_o, lock_o, mem_we_o, irq_o}, 4'b1000);
    rst_ni = 1'b1;
    clear_mon();
    for (int t = 0; t < offset; t++) one_tick(sym);
    for (int i = 0; i < 20; i++) send_bit(1'b1, -1);
    chk(lock_o == 1'b0, "R3", "lock before 32 edges", lock_o, 0);
    for (int i = 0; i < 44; i++) send_bit(1'b1, -1);
    chk(lock_o == 1'b1, "R3", "lock after preamble", lock_o, 1);
    send_frame(r);
    check_load(r, "R6 R1");
    chk(irq_cnt >= 3, "R8", "irq count", irq_cnt, 3);
    for (int k = 0; k < 3; k++)
      chk(irq_word[k] == exp_word(r, BOOT + k), "R8", "run word", irq_word[k], exp_word(r, BOOT + k));
    chk(we_bad == 0, "R8", "write in run mode", we_bad, 0);
    send_bit(1'b0, 4);
    send_bit(1'b0, 11);
    send_bit(1'b0, 4);
    chk(lock_o == 1'b1, "R4", "lock after 6 misses", lock_o, 1);
    send_bit(1'b0, 11);
    chk(lock_o == 1'b0, "R4", "lock after 8 misses", lock_o, 0);
  endtask

  initial begin
    do_run(0, 0, 1'b0);
    do_run(1, 5, 1'b1);
    do_run(2, 9, 1'b0);
    do_run(3, 13, 1'b1);
    // reload without reset
    @(negedge clk_i); reload_i = 1'b1;
    @(negedge clk_i); reload_i = 1'b0;
    chk(hold_cpu_o == 1'b1, "R9", "hold after reload", hold_cpu_o, 1);
    clear_mon();
    for (int i = 0; i < 64; i++) send_bit(1'b1, -1);
    send_frame(9);
    check_load(9, "R9");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule